// File: doc/BRIEF.md
# Pointer-Addressed Word Register Target on I2C

This block is a target on a two-wire I2C bus. A host uses it to read and write a small bank of 16-bit registers. An 8-bit pointer register selects which word is accessed. The block samples SCL and SDA with a system clock much faster than the bus and passes both through a two-flop synchronizer. It drives SDA only by pulling it low; an external pull-up provides the high level.

**Write transaction.** The host sends the target address with the direction bit cleared. The first byte that follows always loads the pointer. The next two bytes form a word, high byte first, which is written into the selected register. A transaction that stops right after the pointer byte is legal. It only moves the pointer, and it lets a later read pick its register without resending anything.

**Read transaction.** Reads return the selected word high byte first, then the low byte. The pointer keeps its value across any number of reads.

**Register bank.** Three registers are writable control words, which are also driven out to the surrounding logic. Two registers are read-only views of input buses. Every other pointer value reads as zero.

Top module: `i2c_word_regs`

## Requirements
- R1: The target answers to the 7-bit address {ADDR_HI, addr_strap[1], addr_strap[0]}. On a match it pulls SDA low for the ninth clock of the address byte. On a mismatch it never pulls SDA low until the next START.
- R2: In a write, the first byte after the address byte is loaded into the pointer and is acknowledged.
- R3: In a write, the two bytes after the pointer byte are acknowledged and stored as {first, second} into the selected writable register.
- R4: A write that ends with STOP or repeated START right after the pointer byte changes the pointer and no register.
- R5: A read returns the selected register high byte first, then low byte. The pointer is unchanged by reads, so repeated reads return the same register.
- R6: A NACK from the host after any data byte makes the target release SDA until the next START. Further clocked bytes read as 0xFF. A STOP or START returns the target to idle from any state.
- R7: Pointer 0x00, 0x03 and 0x04 select the writable words ctrl0, ctrl1 and ctrl2. Pointer 0x01 and 0x02 read ro_a and ro_b. All other values read 0x0000. Writes to read-only or unimplemented pointers are acknowledged and discarded.
- R8: After reset, ctrl0 = 0x0000, ctrl1 = 0x0000, ctrl2 = CTRL2_RST (default 0x0A5C), the pointer is 0x00, and SDA is released.
- R9: The target starts pulling SDA low only while SCL is low. Its SDA drive does not change while SCL stays high.
- R10: If the host ACKs the low byte of a read, the target sends the selected register again, high byte first.
- R11: Data bytes after the second one in a write are acknowledged and have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as sampled |
| sda_in | input | 1 | Bus data line as sampled (wired value) |
| addr_strap | input | 2 | Low two bits of the target address |
| ro_a | input | 16 | Word read at pointer 0x01 |
| ro_b | input | 16 | Word read at pointer 0x02 |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| ctrl0 | output | 16 | Writable word at pointer 0x00 |
| ctrl1 | output | 16 | Writable word at pointer 0x03 |
| ctrl2 | output | 16 | Writable word at pointer 0x04 |

## Verification
A corrupted pointer cannot be seen until the next read. At that point the first data bit already carries the wrong register, so the fault shows within one byte time of the read address. A wrong bit counter or protocol state shows up sooner. It either moves the acknowledge slot, so the host samples a high ninth bit, or it pulls SDA during a mismatched or NACKed transaction, which is caught on the same clock. A stray register write is caught on the first idle clock after the transaction, because ctrl0..ctrl2 are compared with the model on every clock.

// File: rtl/i2c_word_regs.sv
module i2c_word_regs #(
  parameter logic [4:0]  ADDR_HI   = 5'b10001,
  parameter logic [15:0] CTRL2_RST = 16'h0A5C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  input  logic [1:0]  addr_strap,
  input  logic [15:0] ro_a,
  input  logic [15:0] ro_b,
  output logic        sda_oe,
  output logic [15:0] ctrl0,
  output logic [15:0] ctrl1,
  output logic [15:0] ctrl2
);

  localparam logic [7:0] P_CTRL0 = 8'h00;
  localparam logic [7:0] P_ROA   = 8'h01;
  localparam logic [7:0] P_ROB   = 8'h02;
  localparam logic [7:0] P_CTRL1 = 8'h03;
  localparam logic [7:0] P_CTRL2 = 8'h04;
  localparam int         BITS    = 8;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_PTR, S_WDAT, S_RDAT, S_RACK, S_SKIP} st_t;

  st_t         state;
  logic [2:0]  scl_p, sda_p;
  logic [3:0]  bitcnt;
  logic [7:0]  sh, ptr, hold;
  logic [15:0] txsh, rdata;
  logic [1:0]  wbyte;
  logic        rd, rlo, nack;

  wire [6:0] my_addr   = {ADDR_HI, addr_strap};
  wire       scl_s     = scl_p[1];
  wire       scl_q     = scl_p[2];
  wire       sda_s     = sda_p[1];
  wire       sda_q     = sda_p[2];
  wire       scl_rise  = scl_s & ~scl_q;
  wire       scl_fall  = ~scl_s & scl_q;
  wire       start_c   = scl_s & scl_q & sda_q & ~sda_s;
  wire       stop_c    = scl_s & scl_q & ~sda_q & sda_s;
  wire       rx_state  = (state == S_ADDR) || (state == S_PTR) || (state == S_WDAT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
    end

  always_comb
    case (ptr)
      P_CTRL0: rdata = ctrl0;
      P_ROA:   rdata = ro_a;
      P_ROB:   rdata = ro_b;
      P_CTRL1: rdata = ctrl1;
      P_CTRL2: rdata = ctrl2;
      default: rdata = 16'h0000;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state  <= S_IDLE;
      bitcnt <= '0;
      sh     <= '0;
      ptr    <= P_CTRL0;
      hold   <= '0;
      txsh   <= '0;
      wbyte  <= '0;
      rd     <= 1'b0;
      rlo    <= 1'b0;
      nack   <= 1'b0;
      sda_oe <= 1'b0;
      ctrl0  <= '0;
      ctrl1  <= '0;
      ctrl2  <= CTRL2_RST;
    end else if (start_c) begin
      state  <= S_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      state  <= S_IDLE;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        S_ADDR, S_PTR, S_WDAT: begin
          if (scl_rise && bitcnt < BITS) begin
            sh     <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == BITS) begin
            bitcnt <= BITS + 1;
            sda_oe <= 1'b1;
            if (state == S_ADDR) begin
              if (sh[7:1] != my_addr) begin
                sda_oe <= 1'b0;
                state  <= S_SKIP;
              end else begin
                rd   <= sh[0];
                rlo  <= 1'b0;
                txsh <= rdata;
              end
            end else if (state == S_PTR) begin
              ptr <= sh;
            end else begin
              if (wbyte == 2'd0) hold <= sh;
              if (wbyte == 2'd1)
                case (ptr)
                  P_CTRL0: ctrl0 <= {hold, sh};
                  P_CTRL1: ctrl1 <= {hold, sh};
                  P_CTRL2: ctrl2 <= {hold, sh};
                  default: ;
                endcase
              if (wbyte != 2'd2) wbyte <= wbyte + 2'd1;
            end
          end else if (scl_fall && bitcnt == BITS + 1) begin
            bitcnt <= '0;
            if (state == S_ADDR && rd) begin
              state  <= S_RDAT;
              sda_oe <= ~txsh[15];
            end else begin
              sda_oe <= 1'b0;
              if (state == S_ADDR) state <= S_PTR;
              else if (state == S_PTR) begin
                state <= S_WDAT;
                wbyte <= '0;
              end
            end
          end
        end
        S_RDAT: begin
          if (scl_rise) bitcnt <= bitcnt + 4'd1;
          else if (scl_fall) begin
            txsh <= {txsh[14:0], 1'b0};
            if (bitcnt == BITS) begin
              sda_oe <= 1'b0;
              state  <= S_RACK;
              bitcnt <= '0;
            end else begin
              sda_oe <= ~txsh[14];
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            nack   <= sda_s;
            bitcnt <= 4'd1;
          end else if (scl_fall && bitcnt == 4'd1) begin
            bitcnt <= '0;
            if (nack) state <= S_SKIP;
            else begin
              state <= S_RDAT;
              rlo   <= ~rlo;
              if (rlo) begin
                txsh   <= rdata;
                sda_oe <= ~rdata[15];
              end else begin
                sda_oe <= ~txsh[15];
              end
            end
          end
        end
        default: ;
      endcase
    end

  // R9
  drive_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R9
  high_phase_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  // R1
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SKIP) |-> !sda_oe);

  // R5
  ptr_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RDAT || state == S_RACK) |=> $stable(ptr));

  // R7
  ro_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == P_ROA || ptr == P_ROB || ptr > P_CTRL2) |=> $stable({ctrl0, ctrl1, ctrl2}));

  // R1
  ack_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_state && sda_oe) |-> (bitcnt == BITS + 1));

endmodule

// File: tb/i2c_word_regs_test.sv
module i2c_word_regs_test;
  localparam logic [4:0]  HI   = 5'b10001;
  localparam logic [15:0] C2R  = 16'h0A5C;
  localparam int          H    = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        host_low = 1'b0;
  logic [1:0]  strap = 2'b10;
  logic [15:0] ro_a = 16'hC0DE;
  logic [15:0] ro_b = 16'h3344;
  logic        sda_oe;
  logic [15:0] ctrl0, ctrl1, ctrl2;
  logic        sda_bus;

  int total = 0;
  int bad = 0;
  bit cmp_on = 1'b0;
  bit quiet = 1'b0;
  bit done = 1'b0;
  logic [15:0] mreg [0:255];
  logic [7:0]  mptr;

  assign sda_bus = ~(host_low | sda_oe);

  always #10 clk = ~clk;

  i2c_word_regs #(.ADDR_HI(HI), .CTRL2_RST(C2R)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
    .addr_strap(strap), .ro_a(ro_a), .ro_b(ro_b), .sda_oe(sda_oe),
    .ctrl0(ctrl0), .ctrl1(ctrl1), .ctrl2(ctrl2));

  function automatic logic [6:0] dev();
    return {HI, strap};
  endfunction

  function automatic logic [15:0] mread(input logic [7:0] p);
    case (p)
      8'h01: return ro_a;
      8'h02: return ro_b;
      8'h00, 8'h03, 8'h04: return mreg[p];
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // every-clock comparison of the writable words against the model (R3 R7 R11)
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      total++;
      if ({ctrl0, ctrl1, ctrl2} !== {mreg[0], mreg[3], mreg[4]}) begin
        bad++;
        if (bad < 10)
          $display("FAIL R3/R7 ctrl act=%h %h %h exp=%h %h %h",
                   ctrl0, ctrl1, ctrl2, mreg[0], mreg[3], mreg[4]);
      end
    end
    if (rst_n && quiet) begin
      total++;
      if (sda_oe !== 1'b0) begin
        bad++;
        if (bad < 10) $display("FAIL R1/R6 quiet sda_oe act=%b exp=0", sda_oe);
      end
    end
  end

  task automatic bus_start();
    host_low = 1'b0; tick(H);
    scl = 1'b1;      tick(H);
    host_low = 1'b1; tick(H);
    scl = 1'b0;      tick(2);
  endtask

  task automatic bus_stop();
    host_low = 1'b1; tick(H);
    scl = 1'b1;      tick(H);
    host_low = 1'b0; tick(H);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      host_low = ~b[i]; tick(H);
      scl = 1'b1;       tick(H);
      scl = 1'b0;
    end
    host_low = 1'b0; tick(H);
    scl = 1'b1;      tick(H / 2);
    ack = ~sda_bus;  tick(H / 2);
    scl = 1'b0;
  endtask

  task automatic get_byte(output logic [7:0] b, input logic give_nack);
    host_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(H);
      scl = 1'b1; tick(H / 2);
      b[i] = sda_bus; tick(H / 2);
      scl = 1'b0;
    end
    host_low = ~give_nack; tick(H);
    scl = 1'b1; tick(H);
    scl = 1'b0;
    host_low = 1'b0;
  endtask

  task automatic wr_word(input logic [7:0] p, input logic [15:0] w);
    logic a;
    cmp_on = 1'b0;
    bus_start();
    put_byte({dev(), 1'b0}, a); chk("R1 addr ack", a, 1);
    put_byte(p, a);             chk("R2 ptr ack", a, 1);
    put_byte(w[15:8], a);       chk("R3 msb ack", a, 1);
    put_byte(w[7:0], a);        chk("R3 lsb ack", a, 1);
    if (p == 8'h00 || p == 8'h03 || p == 8'h04) mreg[p] = w;
    mptr = p;
    bus_stop();
    tick(4);
    cmp_on = 1'b1;
  endtask

  task automatic set_ptr(input logic [7:0] p);
    logic a;
    bus_start();
    put_byte({dev(), 1'b0}, a); chk("R4 addr ack", a, 1);
    put_byte(p, a);             chk("R4 ptr ack", a, 1);
    mptr = p;
    bus_stop();
  endtask

  task automatic rd_word(input string tag);
    logic a;
    logic [7:0] hi, lo;
    bus_start();
    put_byte({dev(), 1'b1}, a); chk({tag, " rd ack"}, a, 1);
    get_byte(hi, 1'b0);
    get_byte(lo, 1'b1);
    bus_stop();
    chk(tag, {hi, lo}, mread(mptr));
  endtask

  initial begin
    logic a;
    logic [7:0] b0, b1, b2, b3;
    for (int i = 0; i < 256; i++) mreg[i] = 16'h0000;
    mreg[4] = C2R;
    mptr = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(3);
    // R8 reset state
    chk("R8 sda_oe", sda_oe, 0);
    chk("R8 ctrl0", ctrl0, 16'h0000);
    chk("R8 ctrl1", ctrl1, 16'h0000);
    chk("R8 ctrl2", ctrl2, C2R);
    cmp_on = 1'b1;
    rd_word("R8 ptr reset reads ctrl0");

    wr_word(8'h00, 16'h1234);
    wr_word(8'h03, 16'hABCD);
    wr_word(8'h04, 16'h5A0F);
    rd_word("R5 read ctrl2");
    rd_word("R5 reread keeps ptr");

    // R5 pointer set then repeated START into read
    bus_start();
    put_byte({dev(), 1'b0}, a); chk("R1 addr ack rs", a, 1);
    put_byte(8'h03, a);         chk("R2 ptr ack rs", a, 1);
    mptr = 8'h03;
    bus_start();
    put_byte({dev(), 1'b1}, a); chk("R5 rs rd ack", a, 1);
    get_byte(b0, 1'b0);
    get_byte(b1, 1'b1);
    bus_stop();
    chk("R5 rs read ctrl1", {b0, b1}, 16'hABCD);

    // R4 pointer-only writes, R7 read-only views
    set_ptr(8'h01);
    rd_word("R7 ro_a");
    set_ptr(8'h02);
    ro_b = 16'h9876;
    rd_word("R7 ro_b");
    rd_word("R4 ptr persists");

    // R7 writes to read-only and unimplemented pointers are discarded
    wr_word(8'h01, 16'hFFFF);
    rd_word("R7 ro_a unchanged");
    wr_word(8'h80, 16'h4321);
    rd_word("R7 unimpl reads zero");

    // R1 mismatched address: no ack, bus left alone
    cmp_on = 1'b1;
    bus_start();
    quiet = 1'b1;
    put_byte({dev() ^ 7'h01, 1'b0}, a); chk("R1 wrong addr nack", a, 0);
    put_byte(8'h00, a);                 chk("R1 ignored ptr", a, 0);
    put_byte(8'h77, a);                 chk("R1 ignored data", a, 0);
    put_byte(8'h77, a);
    quiet = 1'b0;
    bus_stop();
    bus_start();
    quiet = 1'b1;
    put_byte({dev() ^ 7'h40, 1'b1}, a); chk("R1 wrong rd addr", a, 0);
    get_byte(b0, 1'b1);                 chk("R1 wrong rd data", b0, 8'hFF);
    quiet = 1'b0;
    bus_stop();
    rd_word("R1 ptr untouched by foreign");

    // R1 strap change moves the address
    strap = 2'b01;
    tick(4);
    wr_word(8'h00, 16'h0F0F);
    rd_word("R1 new strap read");

    // R6 NACK after high byte, then bus quiet
    bus_start();
    put_byte({dev(), 1'b1}, a); chk("R6 rd ack", a, 1);
    get_byte(b0, 1'b1);         chk("R6 msb", b0, 8'h0F);
    quiet = 1'b1;
    get_byte(b1, 1'b1);         chk("R6 released after nack", b1, 8'hFF);
    quiet = 1'b0;
    bus_stop();

    // R10 ack after low byte repeats the word
    wr_word(8'h04, 16'hC3A5);
    bus_start();
    put_byte({dev(), 1'b1}, a); chk("R10 rd ack", a, 1);
    get_byte(b0, 1'b0);
    get_byte(b1, 1'b0);
    get_byte(b2, 1'b0);
    get_byte(b3, 1'b1);
    bus_stop();
    chk("R10 first word", {b0, b1}, 16'hC3A5);
    chk("R10 repeated word", {b2, b3}, 16'hC3A5);

    // R11 extra data bytes acked and ignored
    cmp_on = 1'b0;
    bus_start();
    put_byte({dev(), 1'b0}, a); chk("R11 addr ack", a, 1);
    put_byte(8'h03, a);         chk("R11 ptr ack", a, 1);
    put_byte(8'h11, a);         chk("R11 b1 ack", a, 1);
    put_byte(8'h22, a);         chk("R11 b2 ack", a, 1);
    put_byte(8'h99, a);         chk("R11 b3 ack", a, 1);
    put_byte(8'h88, a);         chk("R11 b4 ack", a, 1);
    mreg[3] = 16'h1122;
    mptr = 8'h03;
    bus_stop();
    tick(4);
    cmp_on = 1'b1;
    rd_word("R11 only first two stored");

    tick(20);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule